// File: doc/BRIEF.md
# Network Adapter Host Register File

This block is the byte-wide register file that a host processor reaches through the I/O window of a network adapter. Four writable registers live here: a memory-select register, an interface-configuration register, an interrupt-request register and a high-address register. Together they place and enable the shared-RAM window that the host sees. A rising edge on one control bit issues a soft reset to the packet controller. One bit gates the controller's interrupt toward the host. Seven identification bytes and their checksum can also be read back from the upper half of the offset space.

The register bus is synchronous. The host drives a 4-bit offset, a write strobe and write data. Read data is combinational from the offset and the current register state. A static strap selects the 8-bit board variant, on which every offset folds onto the upper half of the space. A second static strap says whether the slot is 16 bits wide. The window base is built from two address fields in different registers. The address fields survive a warm reset, while the enable and reset-request bits do not.

Top module: `nic_host_regs`

## Requirements
- R1: A write to offset 0 sets window base bits 18:13 from data bits 5:0 and the window enable from data bit 6. Both outputs show the new value from the clock edge that accepts the write.
- R2: A write to offset 5 sets window base bits 23:19 from data bits 4:0. The window base is the OR of both address fields in their positions, with bits 12:0 zero.
- R3: `soft_rst` is high for exactly one clock, the cycle after a write to offset 0. It fires only when that write sets bit 7 while the stored bit 7 was 0. Writing bit 7 again while it is already set gives no pulse.
- R4: A write to offset 4 replaces only bits 4:0 of that register. Bits 7:5 keep their value.
- R5: `irq_out` equals `ctrl_irq` AND bit 7 of the offset-4 register, with no clock delay.
- R6: When `narrow_board` is 1, bit 3 of every offset is forced to 1 for reads and for writes. Writes aimed at offsets 0 to 7 therefore change no register and no output.
- R7: Offsets 8 to 14 read identification byte k = offset-8, taken from `id_bytes[8k+7:8k]`. Offset 15 reads 0xFF minus the low byte of the sum of those seven bytes.
- R8: The first reset after power-up loads these values: offset 0 gets {00, DEF_BASE[18:13]}, offset 5 gets DEF_BASE[23:19], offset 4 gets 0x80, and offset 1 gets 0x00 with `slot16` in bit 0. Every later reset only clears bits 7:6 of offset 0.
- R9: A write to offset 1 stores the full byte, except that bit 0 is forced to 0 while `slot16` is 0.
- R10: Reads of offsets 2, 3, 6 and 7 return 0x00.
- R11: Reads of offsets 0, 1, 4 and 5 return the full stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| narrow_board | input | 1 | Static strap: 8-bit board variant, folds offsets |
| slot16 | input | 1 | Static strap: slot is 16 bits wide |
| id_bytes | input | 56 | Seven identification bytes, byte k in bits 8k+7:8k |
| reg_ofs | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_ofs` |
| ctrl_irq | input | 1 | Interrupt from the packet controller |
| irq_out | output | 1 | Gated interrupt toward the host |
| win_base | output | 24 | Shared-RAM window base address |
| win_en | output | 1 | Shared-RAM window enable |
| soft_rst | output | 1 | One-cycle soft-reset pulse to the controller |

## Verification
The window is programmed in several ways: only the low field, only the high field, both fields, and patterns with all address bits set. These show whether each field lands in its own bit positions and whether the two fields are ORed. Offset 0 receives a sequence of bit-7 values (clear, set, set again, clear, set). This separates edge-triggered soft reset from a level-triggered one. The bench writes all-ones and all-zeros to offset 4, which shows whether the upper bits are protected. A warm reset after the registers have been programmed separates the power-up defaults from a warm clear. Repeating the same accesses with the 8-bit strap set shows whether offsets are folded and whether writes aimed at the lower half are dropped.

// File: rtl/nic_regs_pkg.sv
// Package: shared offsets, field widths and register-set type for the
// network adapter host register file. Assumes a 4-bit, byte-wide offset map.
package nic_regs_pkg;
    localparam int OFS_W  = 4;
    localparam int LO_W   = 6;   // window address field held at offset 0
    localparam int HI_W   = 5;   // window address field held at offset 5
    localparam int ID_N   = 7;   // identification bytes below the checksum
    localparam int FOLD_B = 3;   // offset bit forced on the narrow variant

    typedef logic [OFS_W-1:0] ofs_t;

    localparam ofs_t OFS_MEMSEL = 4'h0;
    localparam ofs_t OFS_IFCFG  = 4'h1;
    localparam ofs_t OFS_IRQREG = 4'h4;
    localparam ofs_t OFS_HIADR  = 4'h5;
    localparam ofs_t OFS_SUM    = 4'hF;

    // Bit positions inside the memory-select and interrupt registers
    localparam int MS_EN_B  = 6;
    localparam int MS_RST_B = 7;
    localparam int IR_EN_B  = 7;

    typedef struct packed {
        logic [7:0] memsel;
        logic [7:0] ifcfg;
        logic [7:0] irqreg;
        logic [7:0] hiadr;
    } regset_t;
endpackage

// File: rtl/nic_addr_fold.sv
// Module: nic_addr_fold
// Applies offset aliasing. On the narrow board variant the selected bit of
// every offset is forced high, so reads and writes both land in the upper half.
// Assumes the strap is static while the bus is in use.
module nic_addr_fold
    import nic_regs_pkg::*;
#(
    parameter int W    = OFS_W,
    parameter int FBIT = FOLD_B
) (
    input  logic         narrow,
    input  logic [W-1:0] ofs_in,
    output logic [W-1:0] ofs_out
);
    localparam logic [W-1:0] FOLD_MASK = W'(1) << FBIT;

    // Force the fold bit when the narrow variant is strapped
    always_comb begin
        ofs_out = narrow ? (ofs_in | FOLD_MASK) : ofs_in;
    end
endmodule

// File: rtl/nic_id_sum.sv
// Module: nic_id_sum
// Selects one identification byte for the upper offsets and forms the
// checksum byte (0xFF minus the low byte of the sum of all ID bytes).
// Assumes the ID bytes occupy offsets 8 .. 8+N-1 and the checksum offset 15.
module nic_id_sum
    import nic_regs_pkg::*;
#(
    parameter int N = ID_N
) (
    input  logic [N*8-1:0] ids,
    input  ofs_t           ofs,
    output logic           hit,
    output logic [7:0]     data
);
    localparam int IDX_W = $clog2(N + 1);

    logic [7:0] part [N+1];
    assign part[0] = 8'h00;

    // Running byte sum, one adder per ID byte
    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_sum
            assign part[k+1] = part[k] + ids[k*8 +: 8];
        end
    endgenerate

    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(ofs[2:0]);

    // Decode the upper half: ID byte, checksum, or miss
    always_comb begin
        hit  = 1'b0;
        data = 8'h00;
        if (ofs == OFS_SUM) begin
            hit  = 1'b1;
            data = 8'hFF - part[N];
        end else if (ofs[3] && (int'(idx) < N)) begin
            hit  = 1'b1;
            data = ids[int'(idx)*8 +: 8];
        end
    end
endmodule

// File: rtl/nic_ctrl_regs.sv
// Module: nic_ctrl_regs
// Holds the four writable registers and issues the soft-reset pulse.
// The first reset after power-up loads the defaults. Each later reset clears
// only the enable and reset-request bits of the memory-select register.
// Assumes the offset input has already been folded.
module nic_ctrl_regs
    import nic_regs_pkg::*;
#(
    parameter int          WIN_LO   = 13,
    parameter logic [31:0] DEF_BASE = 32'h000D_0000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot16,
    input  logic       we,
    input  ofs_t       ofs,
    input  logic [7:0] wdata,
    output regset_t    regs,
    output logic       soft_rst
);
    localparam logic [LO_W-1:0] DEF_LO = DEF_BASE[WIN_LO +: LO_W];
    localparam logic [HI_W-1:0] DEF_HI = DEF_BASE[WIN_LO+LO_W +: HI_W];

    regset_t regs_q;
    logic    cold_q = 1'b1;
    logic    soft_q;

    // Register update: cold defaults, warm clear, or host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (cold_q) begin
                regs_q.memsel <= {2'b00, DEF_LO};
                regs_q.hiadr  <= {{(8-HI_W){1'b0}}, DEF_HI};
                regs_q.irqreg <= 8'h80;
                regs_q.ifcfg  <= {7'b0, slot16};
                cold_q        <= 1'b0;
            end else begin
                regs_q.memsel[MS_RST_B:MS_EN_B] <= 2'b00;
            end
        end else if (we) begin
            case (ofs)
                OFS_MEMSEL: regs_q.memsel <= wdata;
                OFS_IFCFG:  regs_q.ifcfg  <= {wdata[7:1], wdata[0] & slot16};
                OFS_IRQREG: regs_q.irqreg <= {regs_q.irqreg[7:5], wdata[4:0]};
                OFS_HIADR:  regs_q.hiadr  <= wdata;
                default:    ;
            endcase
        end
    end

    // Soft-reset pulse on a 0-to-1 write of the reset-request bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else begin
            soft_q <= we && (ofs == OFS_MEMSEL) && wdata[MS_RST_B]
                      && !regs_q.memsel[MS_RST_B];
        end
    end

    assign regs     = regs_q;
    assign soft_rst = soft_q;

    // R3: the pulse never lasts two cycles
    p_pulse_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |=> !soft_q);

    // R3: a pulse is always caused by a write of bit 7 to offset 0
    p_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |-> ($past(we) && ($past(ofs) == OFS_MEMSEL) && $past(wdata[MS_RST_B])));

    // R4: writes never disturb the upper interrupt-register bits
    p_irq_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $stable(regs_q.irqreg[7:5]));
endmodule

// File: rtl/nic_host_regs.sv
// Module: nic_host_regs (top)
// Host-facing register file of a network adapter. It folds the offset, holds
// the control registers, muxes read data, builds the shared-RAM window base
// and gates the controller interrupt. Read data is combinational.
// Assumes the straps are static during operation.
module nic_host_regs
    import nic_regs_pkg::*;
#(
    parameter int          WIN_LO   = 13,
    parameter logic [31:0] DEF_BASE = 32'h000D_0000,
    localparam int         ADDR_W   = WIN_LO + LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_board,
    input  logic              slot16,
    input  logic [ID_N*8-1:0] id_bytes,
    input  logic [OFS_W-1:0]  reg_ofs,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ctrl_irq,
    output logic              irq_out,
    output logic [ADDR_W-1:0] win_base,
    output logic              win_en,
    output logic              soft_rst
);
    ofs_t       ofs_f;
    regset_t    regs;
    logic       id_hit;
    logic [7:0] id_data;

    nic_addr_fold #(.W(OFS_W), .FBIT(FOLD_B)) i_fold (
        .narrow (narrow_board),
        .ofs_in (reg_ofs),
        .ofs_out(ofs_f)
    );

    nic_ctrl_regs #(.WIN_LO(WIN_LO), .DEF_BASE(DEF_BASE)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot16  (slot16),
        .we      (reg_wr),
        .ofs     (ofs_f),
        .wdata   (reg_wdata),
        .regs    (regs),
        .soft_rst(soft_rst)
    );

    nic_id_sum #(.N(ID_N)) i_id (
        .ids (id_bytes),
        .ofs (ofs_f),
        .hit (id_hit),
        .data(id_data)
    );

    // Read-data mux over the folded offset
    always_comb begin
        case (ofs_f)
            OFS_MEMSEL: reg_rdata = regs.memsel;
            OFS_IFCFG:  reg_rdata = regs.ifcfg;
            OFS_IRQREG: reg_rdata = regs.irqreg;
            OFS_HIADR:  reg_rdata = regs.hiadr;
            default:    reg_rdata = id_hit ? id_data : 8'h00;
        endcase
    end

    // Window base from both address fields, enable from memory-select bit 6
    assign win_base = {regs.hiadr[HI_W-1:0], regs.memsel[LO_W-1:0], {WIN_LO{1'b0}}};
    assign win_en   = regs.memsel[MS_EN_B];

    // Interrupt gate
    assign irq_out  = ctrl_irq & regs.irqreg[IR_EN_B];

    // R1: a write to offset 0 sets the enable on the next cycle
    p_win_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !narrow_board && reg_ofs == OFS_MEMSEL) |=> (win_en == $past(reg_wdata[6])));

    // R2: a write to offset 5 sets the high window bits
    p_hi_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !narrow_board && reg_ofs == OFS_HIADR)
        |=> (win_base[ADDR_W-1 -: HI_W] == $past(reg_wdata[HI_W-1:0])));

    // R6: on the narrow variant writes never move the window or pulse reset
    p_narrow_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && narrow_board) |=> ($stable(win_base) && $stable(win_en) && !soft_rst));
endmodule

// File: tb/test_nic_host_regs.sv
`timescale 1ns/1ps
module test_nic_host_regs;
    localparam int ADDR_W = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_board = 1'b0;
    logic        slot16 = 1'b1;
    logic [55:0] id_bytes;
    logic [3:0]  reg_ofs = 4'h0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        ctrl_irq = 1'b0;
    logic        irq_out;
    logic [ADDR_W-1:0] win_base;
    logic        win_en;
    logic        soft_rst;

    nic_host_regs i_nic_host_regs (
        .clk(clk), .rst_n(rst_n), .narrow_board(narrow_board), .slot16(slot16),
        .id_bytes(id_bytes), .reg_ofs(reg_ofs), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_irq(ctrl_irq),
        .irq_out(irq_out), .win_base(win_base), .win_en(win_en), .soft_rst(soft_rst)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    string phase = "R8";
    bit started = 0;
    bit done = 0;

    byte unsigned ids [7] = '{8'h00, 8'h00, 8'hC0, 8'h12, 8'h34, 8'h56, 8'h03};
    always_comb for (int i = 0; i < 7; i++) id_bytes[i*8 +: 8] = ids[i];

    // Reference model state
    bit       cold = 1;
    bit [7:0] m_ms, m_ic, m_ir, m_hi;
    bit       m_pulse;

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        int a;
        m_pulse = 0;
        a = narrow_board ? (int'(reg_ofs) | 8) : int'(reg_ofs);
        if (!rst_n) begin
            if (cold) begin
                m_ms = 8'((32'h000D_0000 >> 13) & 32'h3F);
                m_hi = 8'((32'h000D_0000 >> 19) & 32'h1F);
                m_ir = 8'h80;
                m_ic = {7'b0, slot16};
                cold = 0;
            end else begin
                m_ms = m_ms & 8'h3F;
            end
        end else if (reg_wr) begin
            if (a == 0) begin
                if (!m_ms[7] && reg_wdata[7]) m_pulse = 1;
                m_ms = reg_wdata;
            end else if (a == 1) m_ic = reg_wdata & (slot16 ? 8'hFF : 8'hFE);
            else if (a == 4) m_ir = (m_ir & 8'hE0) | (reg_wdata & 8'h1F);
            else if (a == 5) m_hi = reg_wdata;
        end
        started = 1;
    end

    function automatic bit [7:0] exp_rd(int o);
        int a = narrow_board ? (o | 8) : o;
        int s = 0;
        case (a)
            0: return m_ms;
            1: return m_ic;
            4: return m_ir;
            5: return m_hi;
            15: begin
                for (int i = 0; i < 7; i++) s += ids[i];
                return 8'(255 - (s % 256));
            end
            default: return (a >= 8) ? ids[a-8] : 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            chk(phase, "rdata R7 R10 R11", {24'b0, reg_rdata}, {24'b0, exp_rd(int'(reg_ofs))});
            chk(phase, "win_base R1 R2", {8'b0, win_base},
                {8'b0, 3'b0, m_hi[4:0], m_ms[5:0], 13'b0});
            chk(phase, "win_en R1", {31'b0, win_en}, {31'b0, m_ms[6]});
            chk(phase, "soft_rst R3", {31'b0, soft_rst}, {31'b0, m_pulse});
            chk(phase, "irq_out R5", {31'b0, irq_out}, {31'b0, ctrl_irq & m_ir[7]});
        end
    end

    task automatic wr(int o, int d);
        @(negedge clk);
        reg_ofs = 4'(o); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int o);
        @(negedge clk);
        reg_ofs = 4'(o); reg_wr = 1'b0;
    endtask

    // Directed check with a literal expectation, sampled mid-cycle
    task automatic rd_lit(string tag, int o, int e);
        rd(o);
        #2;
        chk(tag, "literal read", {24'b0, reg_rdata}, 32'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R8";
        rd_lit("R8", 0, 8'h28);
        rd_lit("R8", 4, 8'h80);
        rd_lit("R8", 5, 8'h01);
        rd_lit("R8", 1, 8'h01);
        #1 chk("R8", "win_base", {8'b0, win_base}, 32'h000D0000);
        phase = "R7";
        rd_lit("R7", 15, 8'hA0);
        for (int o = 8; o < 15; o++) rd(o);
        phase = "R10";
        rd_lit("R10", 2, 0); rd_lit("R10", 3, 0); rd_lit("R10", 6, 0); rd_lit("R10", 7, 0);
        phase = "R1";
        wr(0, 8'h45); rd(0);
        wr(0, 8'h3F); wr(0, 8'h40);
        phase = "R2";
        wr(5, 8'h1A); rd(5);
        wr(5, 8'hFF); wr(0, 8'h7F); rd(0);
        #1 chk("R2", "window all ones", {8'b0, win_base}, 32'h00FFE000);
        phase = "R3";
        wr(0, 8'h05); wr(0, 8'hC5); wr(0, 8'hC7); wr(0, 8'h05); wr(0, 8'h85);
        rd(0); rd(0);
        phase = "R4";
        wr(4, 8'hFF); rd(4); wr(4, 8'h00); rd(4);
        rd_lit("R4", 4, 8'h80);
        phase = "R5";
        rd(0); ctrl_irq = 1'b1; rd(0); rd(0); ctrl_irq = 1'b0; rd(0);
        phase = "R9";
        wr(1, 8'h3F); rd(1);
        slot16 = 1'b0; wr(1, 8'hFF); rd(1);
        rd_lit("R9", 1, 8'hFE);
        slot16 = 1'b1; wr(1, 8'hA5);
        phase = "R11";
        wr(5, 8'hE3); rd_lit("R11", 5, 8'hE3);
        phase = "R8";
        wr(0, 8'hD3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_lit("R8", 0, 8'h13);
        rd_lit("R8", 5, 8'hE3);
        phase = "R6";
        narrow_board = 1'b1;
        for (int o = 0; o < 16; o++) rd(o);
        wr(0, 8'hC0); wr(1, 8'h00); wr(4, 8'h00); wr(5, 8'h00);
        rd_lit("R6", 0, 8'h00);
        rd_lit("R6", 7, 8'hA0);
        narrow_board = 1'b0;
        rd_lit("R6", 0, 8'h13);
        rd_lit("R6", 5, 8'hE3);
        rd(0);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        total++; bad++;
        $display("FAIL watchdog R1: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule